// File: doc/BRIEF.md
# I2C Bus Status and Address Monitor

This block listens passively to the two lines of an I2C bus and keeps a 16-bit status word that a host processor can read at any time. It brings both lines into the local clock domain, then recognises START and STOP conditions and keeps a bus-busy flag. It samples data bits on rising clock edges and shifts each byte into the low half of the word. It records the bit seen in the acknowledge slot. It checks the first byte after every START against a programmable 7-bit own address and against the general-call address.

The upper half of the word carries a 2-bit device-mode field and four event flags. A master engine elsewhere loads the mode field and reports lost arbitration with single-cycle pulses. The host issues START commands and marks each status read with a strobe. Driving the bus, generating the clock and sequencing transfers are done by other blocks.

Top module: `i2c_stat_mon`

## Requirements
- R1: After reset the status word reads 0x0100 (only the busy flag at bit 8 is set) and the own-address readback reads 0x0000.
- R2: Bit 8 (BB) goes to 0 when SDA falls while SCL is high (START) and returns to 1 when SDA rises while SCL is high (STOP). BB low means the bus is busy.
- R3: Each rising SCL edge samples one bit. The first eight bits after a START form a byte that shifts into status bits 7:0 MSB first. The ninth (acknowledge) bit does not enter bits 7:0.
- R4: Bit 12 (LRB) always holds the most recently sampled SDA bit, so after the ninth bit it shows the acknowledge value.
- R5: Bit 11 (AAS) is set when bits 7:1 of the first byte after a START equal the own address or equal 0x00. Bytes later in the transfer never set it.
- R6: A status-read strobe (`stat_rd`) clears AAS on the next clock.
- R7: Bit 10 (LAB) is set by an `arb_lost` pulse and holds until a `host_start` pulse clears it. If both pulses arrive in the same cycle, LAB ends up set.
- R8: Bits 15:14 (MODE) are loaded from `mode_set_val` on `mode_set_en`. Bit 15 selects master (1) or slave (0) and bit 14 selects transmitter (1) or receiver (0). A STOP or an `arb_lost` pulse forces MODE to 00, and this wins over a load in the same cycle.
- R9: Bit 13 (STS) is set by a STOP seen while MODE is 00, is not set by a STOP in any other mode, and is cleared by `stat_rd`.
- R10: A repeated START (START with no STOP before it) restarts the bit count, so the next eight bits form a fresh address byte for the R5 comparison.
- R11: The own address is a 7-bit register written through `own_addr_we`/`own_addr_wd`. It reads back in bits 6:0 of `own_addr_rd`, and bits 15:7 read as zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| scl_in | input | 1 | Raw SCL line level |
| sda_in | input | 1 | Raw SDA line level |
| own_addr_we | input | 1 | Write enable for the own-address register |
| own_addr_wd | input | 7 | New own address |
| own_addr_rd | output | 16 | Own-address readback, upper bits zero |
| mode_set_en | input | 1 | Load pulse for the mode field |
| mode_set_val | input | 2 | Mode value to load |
| arb_lost | input | 1 | Arbitration-lost pulse from the master engine |
| host_start | input | 1 | Host START command pulse |
| stat_rd | input | 1 | Marks that the host read the status word |
| status | output | 16 | Status word |

## Verification
Random transfers pick address bytes three ways: equal to the own address, equal to the general-call value, or arbitrary. This shows whether the match covers both targets and rejects other values. A second byte whose upper seven bits copy the own address checks that only the first byte is compared. Random acknowledge bits and random mode loads before each STOP check LRB capture and whether STS depends on slave-receiver mode. Directed cases cover repeated START after a partial byte, and arbitration loss arriving together with a mode load or a host START.

// File: rtl/i2c_mon_pkg.sv
package i2c_mon_pkg;

  typedef enum logic [1:0] {
    MODE_SR = 2'b00,
    MODE_ST = 2'b01,
    MODE_MR = 2'b10,
    MODE_MT = 2'b11
  } dev_mode_e;

  typedef struct packed {
    dev_mode_e  mode;
    logic       sts;
    logic       lrb;
    logic       aas;
    logic       lab;
    logic       rsvd;
    logic       bb;
    logic [7:0] data;
  } stat_word_t;

endpackage

// File: rtl/i2c_mon_sync.sv
module i2c_mon_sync #(
  parameter int             W       = 2,
  parameter int             STAGES  = 2,
  parameter logic [W-1:0]   RST_VAL = '1
) (
  input  logic         clk,
  input  logic         rst_ni,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);

  logic [STAGES-1:0][W-1:0] stg_q;

  always_ff @(posedge clk or negedge rst_ni) begin
    if (!rst_ni) begin
      stg_q <= {STAGES{RST_VAL}};
    end else begin
      stg_q[0] <= d;
      for (int s = 1; s < STAGES; s++) begin
        stg_q[s] <= stg_q[s-1];
      end
    end
  end

  assign q = stg_q[STAGES-1];

endmodule

// File: rtl/i2c_mon_bits.sv
module i2c_mon_bits
  import i2c_mon_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int ADDR_W = DATA_W - 1
) (
  input  logic              clk,
  input  logic              rst_ni,
  input  logic              scl_s,
  input  logic              sda_s,
  input  logic [ADDR_W-1:0] own_addr,
  output logic              start_det,
  output logic              stop_det,
  output logic              bit_stb,
  output logic [DATA_W-1:0] rx_byte,
  output logic              addr_hit
);

  localparam int               CNT_W    = $clog2(DATA_W + 1);
  localparam logic [CNT_W-1:0] ACK_IDX  = CNT_W'(DATA_W);
  localparam logic [CNT_W-1:0] LAST_IDX = CNT_W'(DATA_W - 1);

  logic              scl_p_q, sda_p_q;
  logic [CNT_W-1:0]  cnt_q, cnt_d;
  logic              first_q, first_d;
  logic [DATA_W-1:0] sh_q, sh_d;
  logic [DATA_W-1:0] byte_full;
  logic [ADDR_W-1:0] addr_field;

  always_comb begin
    bit_stb    = scl_s & ~scl_p_q;
    start_det  = scl_s & scl_p_q & sda_p_q & ~sda_s;
    stop_det   = scl_s & scl_p_q & ~sda_p_q & sda_s;
    byte_full  = {sh_q[DATA_W-2:0], sda_s};
    addr_field = byte_full[DATA_W-1 -: ADDR_W];
    cnt_d      = cnt_q;
    first_d    = first_q;
    sh_d       = sh_q;
    addr_hit   = 1'b0;
    if (start_det) begin
      cnt_d   = '0;
      first_d = 1'b1;
    end else if (stop_det) begin
      cnt_d   = '0;
      first_d = 1'b0;
    end else if (bit_stb) begin
      if (cnt_q == ACK_IDX) begin
        cnt_d   = '0;
        first_d = 1'b0;
      end else begin
        sh_d  = byte_full;
        cnt_d = cnt_q + 1'b1;
        if (first_q && (cnt_q == LAST_IDX)) begin
          addr_hit = (addr_field == own_addr) || (addr_field == '0);
        end
      end
    end
  end

  always_ff @(posedge clk or negedge rst_ni) begin
    if (!rst_ni) begin
      scl_p_q <= 1'b1;
      sda_p_q <= 1'b1;
      cnt_q   <= '0;
      first_q <= 1'b0;
      sh_q    <= '0;
    end else begin
      scl_p_q <= scl_s;
      sda_p_q <= sda_s;
      cnt_q   <= cnt_d;
      first_q <= first_d;
      sh_q    <= sh_d;
    end
  end

  assign rx_byte = sh_q;

  a_r3_cnt_range: assert property (@(posedge clk) disable iff (!rst_ni)
    cnt_q <= ACK_IDX);

  a_r10_start_restarts: assert property (@(posedge clk) disable iff (!rst_ni)
    start_det |=> (cnt_q == '0) && first_q);

endmodule

// File: rtl/i2c_mon_stat.sv
module i2c_mon_stat
  import i2c_mon_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_ni,
  input  logic              start_det,
  input  logic              stop_det,
  input  logic              bit_stb,
  input  logic              sda_s,
  input  logic [DATA_W-1:0] rx_byte,
  input  logic              addr_hit,
  input  logic              mode_set_en,
  input  logic [1:0]        mode_set_val,
  input  logic              arb_lost,
  input  logic              host_start,
  input  logic              stat_rd,
  output stat_word_t        word
);

  dev_mode_e mode_q, mode_d;
  logic      sts_q, sts_d;
  logic      lrb_q, lrb_d;
  logic      aas_q, aas_d;
  logic      lab_q, lab_d;
  logic      bb_q, bb_d;

  always_comb begin
    mode_d = mode_q;
    if (stop_det || arb_lost) begin
      mode_d = MODE_SR;
    end else if (mode_set_en) begin
      mode_d = dev_mode_e'(mode_set_val);
    end

    sts_d = sts_q;
    if (stat_rd) sts_d = 1'b0;
    if (stop_det && (mode_q == MODE_SR)) sts_d = 1'b1;

    lrb_d = bit_stb ? sda_s : lrb_q;

    aas_d = aas_q;
    if (stat_rd)  aas_d = 1'b0;
    if (addr_hit) aas_d = 1'b1;

    lab_d = lab_q;
    if (host_start) lab_d = 1'b0;
    if (arb_lost)   lab_d = 1'b1;

    bb_d = bb_q;
    if (start_det)     bb_d = 1'b0;
    else if (stop_det) bb_d = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_ni) begin
    if (!rst_ni) begin
      mode_q <= MODE_SR;
      sts_q  <= 1'b0;
      lrb_q  <= 1'b0;
      aas_q  <= 1'b0;
      lab_q  <= 1'b0;
      bb_q   <= 1'b1;
    end else begin
      mode_q <= mode_d;
      sts_q  <= sts_d;
      lrb_q  <= lrb_d;
      aas_q  <= aas_d;
      lab_q  <= lab_d;
      bb_q   <= bb_d;
    end
  end

  always_comb begin
    word      = '0;
    word.mode = mode_q;
    word.sts  = sts_q;
    word.lrb  = lrb_q;
    word.aas  = aas_q;
    word.lab  = lab_q;
    word.bb   = bb_q;
    word.data = rx_byte[7:0];
  end

  a_r2_start_busy: assert property (@(posedge clk) disable iff (!rst_ni)
    start_det |=> !bb_q);

  a_r2_stop_idle: assert property (@(posedge clk) disable iff (!rst_ni)
    stop_det |=> bb_q);

  a_r8_forced_sr: assert property (@(posedge clk) disable iff (!rst_ni)
    (stop_det || arb_lost) |=> (mode_q == MODE_SR));

  a_r7_lab_set: assert property (@(posedge clk) disable iff (!rst_ni)
    arb_lost |=> lab_q);

  a_r7_lab_hold: assert property (@(posedge clk) disable iff (!rst_ni)
    (lab_q && !host_start) |=> lab_q);

  a_r6_aas_clear: assert property (@(posedge clk) disable iff (!rst_ni)
    (stat_rd && !addr_hit) |=> !aas_q);

  a_r9_sts_source: assert property (@(posedge clk) disable iff (!rst_ni)
    $rose(sts_q) |-> ($past(stop_det) && ($past(mode_q) == MODE_SR)));

endmodule

// File: rtl/i2c_stat_mon.sv
module i2c_stat_mon
  import i2c_mon_pkg::*;
#(
  parameter int SYNC_STAGES = 2,
  parameter int DATA_W      = 8,
  parameter int ADDR_W      = 7,
  parameter int WORD_W      = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              scl_in,
  input  logic              sda_in,
  input  logic              own_addr_we,
  input  logic [ADDR_W-1:0] own_addr_wd,
  output logic [WORD_W-1:0] own_addr_rd,
  input  logic              mode_set_en,
  input  logic [1:0]        mode_set_val,
  input  logic              arb_lost,
  input  logic              host_start,
  input  logic              stat_rd,
  output logic [WORD_W-1:0] status
);

  logic              rst_ni;
  logic [1:0]        line_s;
  logic              start_det, stop_det, bit_stb, addr_hit;
  logic [DATA_W-1:0] rx_byte;
  logic [ADDR_W-1:0] own_q, own_d;
  stat_word_t        word;

  i2c_mon_sync #(.W(1), .STAGES(2), .RST_VAL(1'b0)) u_rst_sync (
    .clk    (clk),
    .rst_ni (rst_n),
    .d      (1'b1),
    .q      (rst_ni)
  );

  i2c_mon_sync #(.W(2), .STAGES(SYNC_STAGES), .RST_VAL(2'b11)) u_line_sync (
    .clk    (clk),
    .rst_ni (rst_ni),
    .d      ({scl_in, sda_in}),
    .q      (line_s)
  );

  always_comb begin
    own_d = own_addr_we ? own_addr_wd : own_q;
  end

  always_ff @(posedge clk or negedge rst_ni) begin
    if (!rst_ni) own_q <= '0;
    else         own_q <= own_d;
  end

  i2c_mon_bits #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_bits (
    .clk       (clk),
    .rst_ni    (rst_ni),
    .scl_s     (line_s[1]),
    .sda_s     (line_s[0]),
    .own_addr  (own_q),
    .start_det (start_det),
    .stop_det  (stop_det),
    .bit_stb   (bit_stb),
    .rx_byte   (rx_byte),
    .addr_hit  (addr_hit)
  );

  i2c_mon_stat #(.DATA_W(DATA_W)) u_stat (
    .clk          (clk),
    .rst_ni       (rst_ni),
    .start_det    (start_det),
    .stop_det     (stop_det),
    .bit_stb      (bit_stb),
    .sda_s        (line_s[0]),
    .rx_byte      (rx_byte),
    .addr_hit     (addr_hit),
    .mode_set_en  (mode_set_en),
    .mode_set_val (mode_set_val),
    .arb_lost     (arb_lost),
    .host_start   (host_start),
    .stat_rd      (stat_rd),
    .word         (word)
  );

  assign status      = WORD_W'(word);
  assign own_addr_rd = WORD_W'(own_q);

  a_r11_own_write: assert property (@(posedge clk) disable iff (!rst_ni)
    own_addr_we |=> (own_addr_rd[ADDR_W-1:0] == $past(own_addr_wd)));

endmodule

// File: tb/i2c_stat_mon_test.sv
module i2c_stat_mon_test;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        scl_in, sda_in;
  logic        own_addr_we;
  logic [6:0]  own_addr_wd;
  logic [15:0] own_addr_rd;
  logic        mode_set_en;
  logic [1:0]  mode_set_val;
  logic        arb_lost, host_start, stat_rd;
  logic [15:0] status;

  int errs   = 0;
  int checks = 0;
  bit done   = 0;

  logic [1:0] e_mode;
  logic       e_sts, e_lrb, e_aas, e_lab, e_bb, e_first;
  logic [7:0] e_d;
  int         e_cnt;
  logic [6:0] e_own;

  always #2.5 clk = ~clk;

  i2c_stat_mon uut (
    .clk(clk), .rst_n(rst_n), .scl_in(scl_in), .sda_in(sda_in),
    .own_addr_we(own_addr_we), .own_addr_wd(own_addr_wd), .own_addr_rd(own_addr_rd),
    .mode_set_en(mode_set_en), .mode_set_val(mode_set_val),
    .arb_lost(arb_lost), .host_start(host_start), .stat_rd(stat_rd),
    .status(status)
  );

  function automatic logic [15:0] exp_word();
    return {e_mode, e_sts, e_lrb, e_aas, e_lab, 1'b0, e_bb, e_d};
  endfunction

  task automatic chk(input string tag, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      errs++;
      $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic chk_stat(input string tag);
    chk(tag, status, exp_word());
  endtask

  task automatic set_line(input logic c, input logic d);
    @(negedge clk);
    scl_in = c;
    sda_in = d;
    repeat (6) @(negedge clk);
  endtask

  task automatic m_sample(input logic b);
    logic [7:0] nb;
    e_lrb = b;
    if (e_cnt == 8) begin
      e_cnt   = 0;
      e_first = 1'b0;
    end else begin
      nb = {e_d[6:0], b};
      if (e_first && e_cnt == 7 && (nb[7:1] == e_own || nb[7:1] == 7'h00)) e_aas = 1'b1;
      e_d = nb;
      e_cnt++;
    end
  endtask

  task automatic m_start();
    e_bb = 1'b0; e_cnt = 0; e_first = 1'b1;
  endtask

  task automatic t_start();
    set_line(1'b1, 1'b0);
    m_start();
    set_line(1'b0, 1'b0);
  endtask

  task automatic t_bit(input logic b);
    set_line(1'b0, b);
    set_line(1'b1, b);
    m_sample(b);
    set_line(1'b0, b);
  endtask

  task automatic t_byte(input logic [7:0] v);
    for (int i = 7; i >= 0; i--) t_bit(v[i]);
  endtask

  task automatic t_rstart();
    set_line(1'b0, 1'b1);
    set_line(1'b1, 1'b1);
    m_sample(1'b1);
    set_line(1'b1, 1'b0);
    m_start();
    set_line(1'b0, 1'b0);
  endtask

  task automatic t_stop();
    set_line(1'b0, 1'b0);
    set_line(1'b1, 1'b0);
    m_sample(1'b0);
    set_line(1'b1, 1'b1);
    if (e_mode == 2'b00) e_sts = 1'b1;
    e_mode = 2'b00; e_bb = 1'b1; e_cnt = 0; e_first = 1'b0;
  endtask

  task automatic t_pulse(input logic ms, input logic [1:0] mv, input logic al,
                         input logic hs, input logic rd);
    @(negedge clk);
    mode_set_en = ms; mode_set_val = mv; arb_lost = al; host_start = hs; stat_rd = rd;
    @(negedge clk);
    mode_set_en = 1'b0; arb_lost = 1'b0; host_start = 1'b0; stat_rd = 1'b0;
    @(negedge clk);
    if (al) e_mode = 2'b00;
    else if (ms) e_mode = mv;
    if (rd) begin e_sts = 1'b0; e_aas = 1'b0; end
    if (hs) e_lab = 1'b0;
    if (al) e_lab = 1'b1;
  endtask

  task automatic wr_own(input logic [6:0] a);
    @(negedge clk);
    own_addr_we = 1'b1; own_addr_wd = a;
    @(negedge clk);
    own_addr_we = 1'b0;
    @(negedge clk);
    e_own = a;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      errs++;
      checks++;
      $display("FAIL watchdog: actual=timeout expected=finish");
      $display("Result: errors=%0d of %0d checks", errs, checks);
      $finish;
    end
  end

  initial begin
    int unused_seed;
    logic [7:0] ab;
    logic [1:0] mv;
    logic       ack;
    unused_seed = $urandom(32'd4242);
    rst_n = 1'b0; scl_in = 1'b1; sda_in = 1'b1;
    own_addr_we = 1'b0; own_addr_wd = '0;
    mode_set_en = 1'b0; mode_set_val = '0;
    arb_lost = 1'b0; host_start = 1'b0; stat_rd = 1'b0;
    e_mode = 2'b00; e_sts = 0; e_lrb = 0; e_aas = 0; e_lab = 0; e_bb = 1;
    e_first = 0; e_d = '0; e_cnt = 0; e_own = '0;
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    repeat (8) @(negedge clk);

    chk("R1 reset status", status, 16'h0100);
    chk("R1 reset own address", own_addr_rd, 16'h0000);

    wr_own(7'h55);
    chk("R11 own readback", own_addr_rd, 16'h0055);

    // R8: each encoding loads
    for (int m = 0; m < 4; m++) begin
      t_pulse(1'b1, 2'(m), 1'b0, 1'b0, 1'b0);
      chk_stat("R8 mode load");
    end
    t_pulse(1'b1, 2'b11, 1'b1, 1'b0, 1'b0);
    chk_stat("R8 arb loss overrides load");
    chk_stat("R7 lab set");
    t_pulse(1'b0, 2'b00, 1'b0, 1'b1, 1'b0);
    chk_stat("R7 host start clears lab");
    t_pulse(1'b0, 2'b00, 1'b1, 1'b1, 1'b0);
    chk_stat("R7 set wins over clear");
    t_pulse(1'b0, 2'b00, 1'b0, 1'b1, 1'b0);

    // random transfers
    for (int it = 0; it < 36; it++) begin
      wr_own(7'($urandom));
      chk("R11 own readback", own_addr_rd, {9'h0, e_own});
      case ($urandom % 3)
        0: ab = {e_own, 1'($urandom)};
        1: ab = {7'h00, 1'($urandom)};
        default: ab = 8'($urandom);
      endcase
      t_start();
      chk_stat("R2 start busy");
      t_byte(ab);
      chk_stat("R3 R5 address byte");
      ack = 1'($urandom);
      t_bit(ack);
      chk_stat("R4 ack captured, R3 data kept");
      t_pulse(1'b0, 2'b00, 1'b0, 1'b0, 1'b1);
      chk_stat("R6 read clears aas");
      t_byte({e_own, 1'b0});
      t_bit(1'b0);
      chk_stat("R5 later byte no match");
      mv = 2'($urandom);
      if ($urandom % 2 == 1) t_pulse(1'b1, mv, 1'b0, 1'b0, 1'b0);
      t_stop();
      chk_stat("R9 R2 R8 stop");
      t_pulse(1'b0, 2'b00, 1'b0, 1'b0, 1'b1);
      chk_stat("R9 read clears sts");
    end

    // R10: repeated START after partial byte
    wr_own(7'h3C);
    t_start();
    t_bit(1'b1); t_bit(1'b0); t_bit(1'b1); t_bit(1'b1);
    t_rstart();
    chk_stat("R10 repeated start busy");
    t_byte({7'h3C, 1'b1});
    chk_stat("R10 fresh address byte");
    t_bit(1'b0);
    t_pulse(1'b0, 2'b00, 1'b0, 1'b0, 1'b1);
    t_rstart();
    t_byte({7'h00, 1'b0});
    chk_stat("R10 R5 general call after restart");
    t_bit(1'b1);
    chk_stat("R4 nack captured");
    t_pulse(1'b1, 2'b10, 1'b0, 1'b0, 1'b0);
    t_stop();
    chk_stat("R9 no sts in master mode");
    t_pulse(1'b0, 2'b00, 1'b0, 1'b0, 1'b1);
    chk_stat("R6 final read");

    done = 1;
    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end

endmodule